// File: doc/BRIEF.md
# Serial Flash Read Command Target

This block is the device end of a serial flash read link. A host lowers chip select, clocks in an 8-bit command code and a 24-bit address on the serial input, then clocks a run of don't-care bits. After that, each further serial clock moves one bit of stored data out on the serial output. Every field travels most significant bit first. The block keeps three stores inside it: a main array made of 264-byte pages, and two separate 264-byte buffers. All three come out of reset preloaded with a fixed pattern, because this block has no programming path.

The serial pins are sampled in the system clock domain. Each of them passes through a short synchronizer, and the edges of the serial clock are found from the synchronized copy. An input bit is taken on a rising serial clock edge, and the serial output moves on a falling edge. The output is driven only while data is being served. At every other time `so_en_o` is low, which stands for a tri-stated pin. Raising chip select ends a command at any point.

Top module: `sflash_read_target`

## Requirements
- R1: Command code, address and data bits are all MSB first. An input bit is taken on a rising edge of `sck_i`. `so_o` changes only after a falling edge of `sck_i`.
- R2: Command code 0x52 reads the main array. In the 24 address bits, bit 23 down to 21 are unused, bits 20..9 give the page, and bits 8..0 give the starting byte. The page used is the page field modulo NUM_PAGES (a power of two). Byte b of page p holds (b + 3*p) mod 256.
- R3: For a main array read, exactly 32 don't-care bits follow the address. `so_en_o` stays low through the first 31 of them and is high after the 32nd rising edge.
- R4: Command 0x54 reads buffer A, which holds (b mod 256) XOR 0xA5. Command 0x56 reads buffer B, which holds (b mod 256) XOR 0x3C. For both, address bits 23..9 are ignored and bits 8..0 give the starting byte. Exactly 8 don't-care bits come before the data, and `so_en_o` stays low through the first 7 of them.
- R5: After byte 263 the read goes on at byte 0 of the same page or buffer.
- R6: A starting byte field of 264 or more is reduced by 264.
- R7: Any other command code leaves `so_en_o` low for as long as chip select stays low. The next command after chip select rises is served normally.
- R8: `so_en_o` falls within 3 system clocks of `cs_ni` rising. A command that is cut off, even in the middle of its address, does not affect the next command.
- R9: While `rst_ni` is low, `so_en_o` is low, including when reset arrives in the middle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, valid while so_en_o is high |
| so_en_o | output | 1 | Output driver enable; low means high impedance |

## Verification
If the byte pointer or the page register holds a wrong value, the very first data byte at the port is wrong. A bad wrap shows up one byte after the 263rd position. If the phase counter is off by one, the enable rises one serial clock early or late. The bench catches this at the last don't-care bit, and the data then arrives shifted by a bit. If the block fails to return to idle on chip select, it shows as an enable that stays high past three system clocks, or as a corrupted command that follows.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int unsigned PAGE_BYTES = 264;
  localparam int unsigned BYTE_W     = 9;
  localparam int unsigned ADDR_BITS  = 24;
  localparam int unsigned OPC_BITS   = 8;
  localparam int unsigned DUMMY_MAIN = 32;
  localparam int unsigned DUMMY_BUF  = 8;

  localparam logic [7:0] OP_MAIN = 8'h52;
  localparam logic [7:0] OP_BUFA = 8'h54;
  localparam logic [7:0] OP_BUFB = 8'h56;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_IGNORE
  } state_e;

  typedef enum logic [1:0] {SRC_MAIN, SRC_BUFA, SRC_BUFB} src_e;

  function automatic logic [BYTE_W-1:0] fold_byte(input logic [BYTE_W-1:0] b);
    return (b >= BYTE_W'(PAGE_BYTES)) ? b - BYTE_W'(PAGE_BYTES) : b;
  endfunction

  function automatic logic [BYTE_W-1:0] next_byte(input logic [BYTE_W-1:0] b);
    return (b == BYTE_W'(PAGE_BYTES - 1)) ? '0 : b + BYTE_W'(1);
  endfunction
endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic cs_o,
  output logic si_o,
  output logic rise_o,
  output logic fall_o
);
  // bit 0: cs, bit 1: sck, bit 2: si
  localparam logic [2:0] RST_VAL = 3'b001;

  logic [2:0] pipe [STAGES];
  logic       sck_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= {si_i, sck_i, cs_ni};
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe[g] <= RST_VAL;
        else         pipe[g] <= pipe[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= pipe[STAGES-1][1];

  assign cs_o   = pipe[STAGES-1][0];
  assign si_o   = pipe[STAGES-1][2];
  assign rise_o =  pipe[STAGES-1][1] & ~sck_d;
  assign fall_o = ~pipe[STAGES-1][1] &  sck_d;
endmodule

// File: rtl/sflash_cmd.sv
module sflash_cmd
  import sflash_pkg::*;
#(
  parameter int unsigned PAGE_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                si_i,
  input  logic                rise_i,
  input  logic                fall_i,
  input  logic [7:0]          rd_byte_i,
  output state_e              state_o,
  output src_e                src_o,
  output logic [PAGE_W-1:0]   page_o,
  output logic [BYTE_W-1:0]   ptr_o,
  output logic                so_o
);
  localparam int unsigned CNT_W = 6;

  state_e               state_q;
  src_e                 src_q;
  logic [ADDR_BITS-1:0] sh_q;
  logic [ADDR_BITS-1:0] sh_next;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     dummy_last;
  logic [2:0]           bit_q;
  logic [PAGE_W-1:0]    page_q;
  logic [BYTE_W-1:0]    ptr_q;
  logic                 so_q;

  assign sh_next    = {sh_q[ADDR_BITS-2:0], si_i};
  assign dummy_last = (src_q == SRC_MAIN) ? CNT_W'(DUMMY_MAIN - 1) : CNT_W'(DUMMY_BUF - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= SRC_MAIN;
      sh_q    <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      page_q  <= '0;
      ptr_q   <= '0;
      so_q    <= 1'b0;
    end else if (cs_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_OPC;
          cnt_q   <= '0;
        end
        ST_OPC: if (rise_i) begin
          sh_q  <= sh_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(OPC_BITS - 1)) begin
            cnt_q <= '0;
            case (sh_next[7:0])
              OP_MAIN: begin src_q <= SRC_MAIN; state_q <= ST_ADDR; end
              OP_BUFA: begin src_q <= SRC_BUFA; state_q <= ST_ADDR; end
              OP_BUFB: begin src_q <= SRC_BUFB; state_q <= ST_ADDR; end
              default: state_q <= ST_IGNORE;
            endcase
          end
        end
        ST_ADDR: if (rise_i) begin
          sh_q  <= sh_next;
          cnt_q <= cnt_q + CNT_W'(1);
          if (cnt_q == CNT_W'(ADDR_BITS - 1)) begin
            cnt_q   <= '0;
            page_q  <= sh_next[BYTE_W +: PAGE_W];
            ptr_q   <= fold_byte(sh_next[BYTE_W-1:0]);
            state_q <= ST_DUMMY;
          end
        end
        ST_DUMMY: if (rise_i) begin
          if (cnt_q == dummy_last) begin
            cnt_q   <= '0;
            bit_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: if (fall_i) begin
          so_q  <= rd_byte_i[3'd7 - bit_q];
          bit_q <= bit_q + 3'd1;
          if (bit_q == 3'd7) ptr_q <= next_byte(ptr_q);
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign src_o   = src_q;
  assign page_o  = page_q;
  assign ptr_o   = ptr_q;
  assign so_o    = so_q;
endmodule

// File: rtl/sflash_mem.sv
module sflash_mem
  import sflash_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  parameter int unsigned PAGE_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  src_e              src_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [BYTE_W-1:0] ptr_i,
  output logic [7:0]        rd_byte_o
);
  localparam int unsigned MAIN_DEPTH = NUM_PAGES * PAGE_BYTES;
  localparam int unsigned IDX_W      = $clog2(MAIN_DEPTH);

  logic [7:0]       main_mem [MAIN_DEPTH];
  logic [1:0][7:0]  buf_rd;
  logic [IDX_W-1:0] main_idx;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)
      for (int p = 0; p < int'(NUM_PAGES); p++)
        for (int b = 0; b < int'(PAGE_BYTES); b++)
          main_mem[p*PAGE_BYTES + b] <= 8'((b + 3*p) % 256);

  for (genvar g = 0; g < 2; g++) begin : g_buf
    localparam logic [7:0] KEY = (g == 0) ? 8'hA5 : 8'h3C;
    logic [7:0] mem [PAGE_BYTES];
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)
        for (int b = 0; b < int'(PAGE_BYTES); b++)
          mem[b] <= 8'(b % 256) ^ KEY;
    assign buf_rd[g] = mem[ptr_i];
  end

  assign main_idx = IDX_W'(page_i) * IDX_W'(PAGE_BYTES) + IDX_W'(ptr_i);

  always_comb begin
    unique case (src_i)
      SRC_BUFA: rd_byte_o = buf_rd[0];
      SRC_BUFB: rd_byte_o = buf_rd[1];
      default:  rd_byte_o = main_mem[main_idx];
    endcase
  end
endmodule

// File: rtl/sflash_read_target.sv
module sflash_read_target
  import sflash_pkg::*;
#(
  parameter int unsigned NUM_PAGES   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_en_o
);
  localparam int unsigned PAGE_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

  logic              cs_s, si_s, sck_rise, sck_fall, so_q;
  logic [7:0]        rd_byte;
  state_e            state;
  src_e              src;
  logic [PAGE_W-1:0] page;
  logic [BYTE_W-1:0] ptr;

  sflash_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .si_i,
    .cs_o(cs_s), .si_o(si_s), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  sflash_cmd #(.PAGE_W(PAGE_W)) u_cmd (
    .clk_i, .rst_ni, .cs_i(cs_s), .si_i(si_s),
    .rise_i(sck_rise), .fall_i(sck_fall), .rd_byte_i(rd_byte),
    .state_o(state), .src_o(src), .page_o(page), .ptr_o(ptr), .so_o(so_q)
  );

  sflash_mem #(.NUM_PAGES(NUM_PAGES), .PAGE_W(PAGE_W)) u_mem (
    .clk_i, .rst_ni, .src_i(src), .page_i(page), .ptr_i(ptr), .rd_byte_o(rd_byte)
  );

  assign so_en_o = (state == ST_DATA) && !cs_s;
  assign so_o    = so_q & so_en_o;
endmodule

// File: rtl/sflash_read_target_chk.sv
module sflash_read_target_chk
  import sflash_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              so_en_o,
  input state_e            state,
  input logic [BYTE_W-1:0] ptr
);
  p_ptr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr < BYTE_W'(PAGE_BYTES));

  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && $past(state) == ST_DATA && ptr != $past(ptr)) |->
      ptr == (($past(ptr) == BYTE_W'(PAGE_BYTES - 1)) ? '0 : $past(ptr) + BYTE_W'(1)));

  p_oe_only_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_en_o |-> state == ST_DATA);

  p_ignore_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_IGNORE |-> !so_en_o);

  p_cs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !so_en_o);

  p_reset_quiet_r9: assert property (@(posedge clk_i)
    !rst_ni |-> !so_en_o);
endmodule

bind sflash_read_target sflash_read_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .so_en_o(so_en_o),
  .state(state), .ptr(ptr)
);

// File: tb/sflash_read_target_test.sv
module sflash_read_target_test;
  localparam int NPAGES = 4;
  localparam int HALF   = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b1;
  logic cs_ni = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_en;
  int   n_run = 0, n_fail = 0;
  bit   done = 0;

  always #5 clk = ~clk;

  sflash_read_target #(.NUM_PAGES(NPAGES)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sck_i(sck), .si_i(si),
    .so_o(so), .so_en_o(so_en)
  );

  // {opcode[35:28], address[27:4], byte count[3:0]}
  localparam logic [35:0] VEC [7] = '{
    {8'h52, 3'b000, 12'd1,  9'd0,   4'd4},
    {8'h52, 3'b000, 12'd3,  9'd262, 4'd4},
    {8'h54, 15'h2ABC,       9'd10,  4'd3},
    {8'h56, 15'h0000,       9'd263, 4'd3},
    {8'h52, 3'b000, 12'd2,  9'd300, 4'd3},
    {8'h54, 15'h0000,       9'd400, 4'd2},
    {8'h52, 3'b101, 12'd5,  9'd511, 4'd3}
  };

  function automatic logic [7:0] exp_byte(input logic [7:0] op, input logic [23:0] a, input int k);
    int start, b, pg;
    start = int'(a[8:0]);
    if (start >= 264) start -= 264;
    b  = (start + k) % 264;
    pg = int'(a[20:9]) % NPAGES;
    case (op)
      8'h54:   return 8'(b % 256) ^ 8'hA5;
      8'h56:   return 8'(b % 256) ^ 8'h3C;
      default: return 8'((b + 3*pg) % 256);
    endcase
  endfunction

  task automatic wait_half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic o, output logic oe);
    si = b;
    wait_half();
    o  = so;
    oe = so_en;
    sck = 1'b1;
    wait_half();
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o, oe;
    for (int i = n - 1; i >= 0; i--) bit_io(v[i], o, oe);
  endtask

  task automatic read_byte(output logic [7:0] d);
    logic o, oe;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b0, o, oe);
      d[i] = o;
    end
  endtask

  task automatic cs_low();
    @(negedge clk);
    cs_ni = 1'b0;
    wait_half();
  endtask

  task automatic cs_high();
    cs_ni = 1'b1;
    wait_half();
  endtask

  task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int n, input string tag);
    int nd;
    logic [7:0] d;
    nd = (op == 8'h52) ? 32 : 8;
    cs_low();
    send({24'd0, op}, 8);
    send({8'd0, a}, 24);
    send(32'hFFFF_FFFF, nd - 1);
    check(so_en == 1'b0, (op == 8'h52) ? "R3 enable low before last dummy" : "R4 enable low before last dummy",
          int'(so_en), 0);
    send(32'h0, 1);
    check(so_en == 1'b1, (op == 8'h52) ? "R3 enable after dummies" : "R4 enable after dummies",
          int'(so_en), 1);
    for (int k = 0; k < n; k++) begin
      read_byte(d);
      check(d == exp_byte(op, a, k), tag, int'(d), int'(exp_byte(op, a, k)));
    end
    cs_high();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic o, oe, seen;
    logic [7:0] d;
    #2 rst_ni = 1'b0;
    repeat (4) @(negedge clk);
    check(so_en == 1'b0, "R9 enable low in reset", int'(so_en), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(so_en == 1'b0, "R9 enable low after reset", int'(so_en), 0);

    // main table: R1 R2 R4 R5 R6
    for (int v = 0; v < 7; v++)
      run_cmd(VEC[v][35:28], VEC[v][27:4], int'(VEC[v][3:0]), $sformatf("R1 R2 R4 R5 R6 data vec %0d", v));

    // R7: unknown command stays silent, next command served
    cs_low();
    send(32'h53, 8);
    seen = 1'b0;
    for (int i = 0; i < 64; i++) begin
      bit_io(i[0], o, oe);
      seen |= oe;
    end
    check(seen == 1'b0, "R7 unknown command silent", int'(seen), 0);
    cs_high();
    run_cmd(8'h56, 24'd5, 1, "R7 command after unknown");

    // R8: abort inside data
    cs_low();
    send(32'h52, 8);
    send(32'h0, 24);
    send(32'h0, 32);
    read_byte(d);
    send(32'h0, 3);
    cs_ni = 1'b1;
    repeat (4) @(negedge clk);
    check(so_en == 1'b0, "R8 enable off after cs rise", int'(so_en), 0);
    wait_half();
    run_cmd(8'h52, {3'b0, 12'd1, 9'd7}, 2, "R8 restart after data abort");

    // R8: abort inside address
    cs_low();
    send(32'h54, 8);
    send(32'h3FF, 10);
    cs_high();
    run_cmd(8'h52, {3'b0, 12'd2, 9'd263}, 2, "R8 restart after address abort");

    // R9: reset during data
    cs_low();
    send(32'h52, 8);
    send(32'h0, 24);
    send(32'h0, 32);
    read_byte(d);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    check(so_en == 1'b0, "R9 enable low on reset in data", int'(so_en), 0);
    rst_ni = 1'b1;
    cs_high();
    run_cmd(8'h54, 24'd263, 2, "R9 read after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule